// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block stores one control flag for every pairing of an output stream with a channel. With the defaults that is eight streams and thirty-two channels, so 256 flags. It plays those flags back as a continuous serial control line. One frame of the line carries 256 bits and lines up with the frame of the serial data streams. Each bit lasts two cycles of the block clock. The block clock is the 4.096 MHz bit clock, which gives a 2.048 Mbit/s line.

Inside each timeslot the line sends eight bits, one for each stream, lowest stream number first. A timeslot carries the group for the channel after it, so an external circuit has a full timeslot to switch before that channel's data passes. An example of such a circuit is a per-channel loopback switch. The group for channel 0 is therefore sent in the last timeslot of the frame before.

A host changes flags through a write port that uses a valid/ready handshake. The block never applies back-pressure: ready is always high, and a write is taken on any clock edge at which valid is high. Frame alignment comes from an active-low frame pulse. Between pulses the bit position runs freely and wraps every 512 clocks. The control line is a plain output and is driven at all times.

Top module: `chanctl_serializer`

## Requirements
- R1: While rst_n is low, and after it is released, every flag reads 0 and the line is low. The bit position starts at bit 0 of timeslot 0, in the first cycle of that bit.
- R2: When frame_n is sampled low at a rising clock edge, the cycle that follows is the first cycle of bit 0. This holds wherever the frame was.
- R3: Each bit holds for CLK_PER_BIT (2) clocks. A frame has 256 bits. With no frame pulse the position wraps from bit 255 back to bit 0 every 512 clocks.
- R4: Bit k of the frame lies in timeslot k[7:3] and belongs to stream k[2:0]. Its value is the flag of that stream for channel (k[7:3]+1) mod 32. So channel 0 is sent in timeslot 31.
- R5: A flag of 1 drives ctl_out high and a flag of 0 drives it low. ctl_out is never undefined and has no enable.
- R6: wr_ready is always 1. On an edge with wr_valid high, the flag chosen by wr_stream (3 bits) and wr_chan (5 bits) takes the value of wr_flag.
- R7: A write taken at an edge is used by every bit loaded at a later edge. ctl_out changes only at bit boundaries, so a write made while a flag is on the line, or at the edge that loads it, does not change the bit already sent.
- R8: With wr_valid low, the values on wr_stream, wr_chan and wr_flag change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per line bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame alignment pulse |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_stream | input | 3 | Stream number of the flag to write |
| wr_chan | input | 5 | Channel number of the flag to write |
| wr_flag | input | 1 | New flag value |
| ctl_out | output | 1 | Serial control line |

## Verification
ctl_out is a register. It loads at the edge where the position enters a new bit, so a bit becomes visible in the same cycle as that edge, not a cycle later. The bench keeps its own frame position and flag model, updated at each rising edge. It samples ctl_out at the falling edge after the edge that set the position. After a frame pulse taken at edge E, bit 0 is checked half a cycle after E. A write taken at edge E can only appear in bits loaded at later edges, so the model holds the old value for a load at E. The write corner cases are checked in the same half of the bit, and again one frame later.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;
  localparam int DEF_STREAMS     = 8;
  localparam int DEF_CHANS       = 32;
  localparam int DEF_CLK_PER_BIT = 2;
endpackage

// File: rtl/chanctl_timebase.sv
module chanctl_timebase #(
  parameter int CLK_PER_BIT = 2,
  parameter int BITS        = 256,
  localparam int PH_W       = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1,
  localparam int BIT_W      = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  output logic [PH_W-1:0]  phase_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [BIT_W-1:0] nxt_bit_o,
  output logic             load_o
);
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             last_phase;

  generate
    if (CLK_PER_BIT == 1) begin : g_single
      assign last_phase = 1'b1;
    end else begin : g_multi
      assign last_phase = (phase_q == PH_W'(CLK_PER_BIT - 1));
    end
  endgenerate

  always_comb begin
    if (!frame_n) begin
      phase_d = '0;
      bit_d   = '0;
    end else if (last_phase) begin
      phase_d = '0;
      bit_d   = (bit_q == BIT_W'(BITS - 1)) ? '0 : bit_q + 1'b1;
    end else begin
      phase_d = phase_q + 1'b1;
      bit_d   = bit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  assign phase_o   = phase_q;
  assign bit_o     = bit_q;
  assign nxt_bit_o = bit_d;
  assign load_o    = (phase_d == '0);
endmodule

// File: rtl/chanctl_flag_store.sv
module chanctl_flag_store #(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CHANS   = 32,
  localparam int S_W        = $clog2(NUM_STREAMS),
  localparam int C_W        = $clog2(NUM_CHANS),
  localparam int FLAGS      = NUM_STREAMS * NUM_CHANS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [S_W-1:0]   wr_stream,
  input  logic [C_W-1:0]   wr_chan,
  input  logic             wr_flag,
  input  logic [S_W-1:0]   rd_stream,
  input  logic [C_W-1:0]   rd_chan,
  output logic             rd_flag,
  output logic [FLAGS-1:0] flags_o
);
  logic [FLAGS-1:0] flag_q;

  generate
    for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
      for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            flag_q[c*NUM_STREAMS + s] <= 1'b0;
          else if (wr_en && wr_chan == C_W'(c) && wr_stream == S_W'(s))
            flag_q[c*NUM_STREAMS + s] <= wr_flag;
        end
      end
    end
  endgenerate

  assign rd_flag = flag_q[{rd_chan, rd_stream}];
  assign flags_o = flag_q;
endmodule

// File: rtl/chanctl_sequencer.sv
module chanctl_sequencer #(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CHANS   = 32,
  localparam int S_W        = $clog2(NUM_STREAMS),
  localparam int C_W        = $clog2(NUM_CHANS),
  localparam int BIT_W      = S_W + C_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BIT_W-1:0] nxt_bit,
  input  logic             load,
  output logic [S_W-1:0]   rd_stream,
  output logic [C_W-1:0]   rd_chan,
  input  logic             rd_flag,
  output logic             ctl_out
);
  logic ctl_q;

  // the group sent in a timeslot belongs to the following channel
  assign rd_stream = nxt_bit[S_W-1:0];
  assign rd_chan   = nxt_bit[BIT_W-1:S_W] + C_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= 1'b0;
    else if (load)
      ctl_q <= rd_flag;
  end

  assign ctl_out = ctl_q;
endmodule

// File: rtl/chanctl_serializer.sv
module chanctl_serializer
  import chanctl_pkg::*;
#(
  parameter int NUM_STREAMS = DEF_STREAMS,
  parameter int NUM_CHANS   = DEF_CHANS,
  parameter int CLK_PER_BIT = DEF_CLK_PER_BIT,
  localparam int S_W        = $clog2(NUM_STREAMS),
  localparam int C_W        = $clog2(NUM_CHANS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [S_W-1:0] wr_stream,
  input  logic [C_W-1:0] wr_chan,
  input  logic           wr_flag,
  output logic           ctl_out
);
  localparam int BITS  = NUM_STREAMS * NUM_CHANS;
  localparam int BIT_W = S_W + C_W;
  localparam int PH_W  = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;

  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bit_idx, nxt_bit;
  logic             load_next;
  logic [S_W-1:0]   rd_stream;
  logic [C_W-1:0]   rd_chan;
  logic             rd_flag;
  logic [BITS-1:0]  flag_vec;

  assign wr_ready = 1'b1;

  chanctl_timebase #(.CLK_PER_BIT(CLK_PER_BIT), .BITS(BITS)) tb_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
    .phase_o(phase), .bit_o(bit_idx), .nxt_bit_o(nxt_bit), .load_o(load_next)
  );

  chanctl_flag_store #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid && wr_ready),
    .wr_stream(wr_stream), .wr_chan(wr_chan), .wr_flag(wr_flag),
    .rd_stream(rd_stream), .rd_chan(rd_chan), .rd_flag(rd_flag),
    .flags_o(flag_vec)
  );

  chanctl_sequencer #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS)) seq_i (
    .clk(clk), .rst_n(rst_n), .nxt_bit(nxt_bit), .load(load_next),
    .rd_stream(rd_stream), .rd_chan(rd_chan), .rd_flag(rd_flag),
    .ctl_out(ctl_out)
  );
endmodule

// File: rtl/chanctl_checker.sv
module chanctl_checker #(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CHANS   = 32,
  parameter int CLK_PER_BIT = 2,
  localparam int S_W        = $clog2(NUM_STREAMS),
  localparam int C_W        = $clog2(NUM_CHANS),
  localparam int BITS       = NUM_STREAMS * NUM_CHANS,
  localparam int BIT_W      = S_W + C_W,
  localparam int PH_W       = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [S_W-1:0]   wr_stream,
  input logic [C_W-1:0]   wr_chan,
  input logic             wr_flag,
  input logic             ctl_out,
  input logic [PH_W-1:0]  phase,
  input logic [BIT_W-1:0] bit_idx,
  input logic             load_next,
  input logic [BITS-1:0]  flag_vec
);
  logic [BIT_W-1:0] wr_idx;
  assign wr_idx = {wr_chan, wr_stream};

  assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (phase == '0 && bit_idx == '0));

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && phase != PH_W'(CLK_PER_BIT - 1)) |=>
      (bit_idx == $past(bit_idx) && phase == $past(phase) + 1'b1));

  assert_bit_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && phase == PH_W'(CLK_PER_BIT - 1) && bit_idx != BIT_W'(BITS - 1)) |=>
      (bit_idx == $past(bit_idx) + 1'b1 && phase == '0));

  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && phase == PH_W'(CLK_PER_BIT - 1) && bit_idx == BIT_W'(BITS - 1)) |=>
      (bit_idx == '0));

  assert_line_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(ctl_out));

  assert_flag_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> flag_vec[$past(wr_idx)] == $past(wr_flag));

  assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_next |=> $stable(ctl_out));
endmodule

bind chanctl_serializer chanctl_checker #(
  .NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS), .CLK_PER_BIT(CLK_PER_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_stream(wr_stream), .wr_chan(wr_chan),
  .wr_flag(wr_flag), .ctl_out(ctl_out), .phase(phase), .bit_idx(bit_idx),
  .load_next(load_next), .flag_vec(flag_vec)
);

// File: tb/chanctl_serializer_tb_top.sv
module chanctl_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, frame_n, wr_valid, wr_ready, wr_flag, ctl_out;
  logic [2:0] wr_stream;
  logic [4:0] wr_chan;

  always #4 clk = ~clk;

  chanctl_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_stream(wr_stream), .wr_chan(wr_chan),
    .wr_flag(wr_flag), .ctl_out(ctl_out)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  int   bpos;
  logic exp_line;
  logic mdl [256];
  logic cap [256];

  // stream, channel, value, expected bit position in the frame
  localparam bit [16:0] VEC [9] = '{
    {3'd0, 5'd1,  1'b1, 8'd0},
    {3'd7, 5'd1,  1'b1, 8'd7},
    {3'd3, 5'd0,  1'b1, 8'd251},
    {3'd7, 5'd0,  1'b1, 8'd255},
    {3'd0, 5'd31, 1'b1, 8'd240},
    {3'd4, 5'd16, 1'b1, 8'd124},
    {3'd2, 5'd9,  1'b1, 8'd66},
    {3'd6, 5'd20, 1'b1, 8'd158},
    {3'd5, 5'd2,  1'b1, 8'd13}
  };

  function automatic int line_idx(input int p);
    int k, ch;
    k  = p / 2;
    ch = (k / 8 + 1) % 32;
    return ch * 8 + (k % 8);
  endfunction

  // reference position and flag model (R3, R4, R7)
  always @(posedge clk) begin : model
    int np;
    if (!rst_n) begin
      bpos     <= 0;
      exp_line <= 1'b0;
      for (int i = 0; i < 256; i++) mdl[i] <= 1'b0;
    end else begin
      np = !frame_n ? 0 : ((bpos == 511) ? 0 : bpos + 1);
      bpos <= np;
      if (np % 2 == 0) exp_line <= mdl[line_idx(np)];
      if (wr_valid) mdl[int'(wr_chan) * 8 + int'(wr_stream)] <= wr_flag;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b bpos=%0d", req, act, exp, bpos);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [4:0] c, input logic v);
    wr_stream = s; wr_chan = c; wr_flag = v; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, ctl_out, exp_line);
    end
  endtask

  task automatic wait_pos(input int p);
    @(negedge clk);
    while (bpos != p) @(negedge clk);
  endtask

  task automatic pulse();
    frame_n = 1'b0;
    @(negedge clk);
    frame_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; wr_valid = 1'b0;
    wr_stream = '0; wr_chan = '0; wr_flag = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 line low in reset", ctl_out, 1'b0);
    rst_n = 1'b1;
    chk("R6 ready high", wr_ready, 1'b1);
    run(512, "R1 all flags zero");

    // table walk: load flags, align, capture one frame
    for (int i = 0; i < 9; i++) wr(VEC[i][16:14], VEC[i][13:9], VEC[i][8]);
    chk("R6 ready high after writes", wr_ready, 1'b1);
    pulse();
    for (int i = 0; i < 512; i++) begin
      chk("R5 line follows flag", ctl_out, exp_line);
      if (i % 2 == 0) cap[i/2] = ctl_out;
      else chk("R3 bit held two clocks", ctl_out, cap[i/2]);
      @(negedge clk);
    end
    chk("R3 free-running wrap", ctl_out, cap[0]);
    for (int i = 0; i < 9; i++)
      chk("R4 stream/channel order", cap[VEC[i][7:0]], VEC[i][8]);
    chk("R4 channel 0 gap neighbour", cap[250], 1'b0);

    // write while flag on line: stream 5 channel 10 is bit 77 (cycles 154/155)
    wait_pos(154);
    chk("R7 old bit before write", ctl_out, 1'b0);
    wr(3'd5, 5'd10, 1'b1);
    chk("R7 bit on line unchanged", ctl_out, 1'b0);
    wait_pos(154);
    chk("R7 new value next frame", ctl_out, 1'b1);

    // write at the load edge: stream 1 channel 1 is bit 1, loaded entering cycle 2
    wait_pos(1);
    wr(3'd1, 5'd1, 1'b1);
    chk("R7 load-edge write not seen", ctl_out, 1'b0);
    wait_pos(2);
    chk("R7 load-edge write next frame", ctl_out, 1'b1);

    // idle write fields: stream 2 channel 7 is bit 50 (cycle 100)
    wr_stream = 3'd2; wr_chan = 5'd7; wr_flag = 1'b1; wr_valid = 1'b0;
    run(512, "R8 model match with valid low");
    wait_pos(100);
    chk("R8 flag unchanged", ctl_out, 1'b0);

    // realign mid-frame; bit 150 is 0, bit 0 is 1, bit 1 is now 1, bit 2 is 0
    wait_pos(300);
    chk("R2 before pulse", ctl_out, 1'b0);
    pulse();
    chk("R2 bit 0 after pulse", ctl_out, 1'b1);
    @(negedge clk);
    chk("R2 bit 0 second clock", ctl_out, 1'b1);
    @(negedge clk);
    chk("R2 bit 1", ctl_out, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R2 bit 2", ctl_out, 1'b0);
    run(600, "R5 model match after realign");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule